// File: doc/BRIEF.md
# Three-Axis Sample Frame FIFO

This block buffers three-axis sample frames, up to 32 of them. Each frame holds one signed sample for each axis. Software picks one of four fill policies through a two-bit mode input.

- **Bypass** keeps only the newest frame.
- **Stop** accepts frames until the buffer is full, then drops new ones.
- **Stream** always accepts new frames and discards the oldest entry when full.
- **Triggered** runs as stream until a selected event arrives, then behaves as stop. The event is either a motion event or a click event.

A consumer pops frames with a read strobe. The frame at the head of the buffer is always presented on `readFrame`.

Status is reported continuously:

- an unread-sample count field,
- a watermark flag, compared against a programmable level,
- a full/overrun flag,
- an empty flag.

The watermark and overrun conditions each drive an interrupt request, gated by its own enable.

Top module: `sample_frame_fifo`

## Requirements
- R1: After reset the buffer is empty: `emptyFlag`=1, `unreadCount`=0, and `wmFlag`, `overrunFlag`, `wmIrq` and `ovrIrq` are all 0.
- R2: Frames leave in the order they were accepted. `readFrame` shows the oldest unread frame, and `readStrobe` removes it. A read strobe while empty changes nothing.
- R3: In stop mode (`mode`=2'b01), a frame offered while 32 are held is dropped, and the held contents stay unchanged.
- R4: In stream mode (`mode`=2'b10), a frame offered while 32 are held replaces the oldest one. The held count stays at 32.
- R5: In stream mode with 32 held, a read and a write in the same cycle return the oldest frame, accept the new one, and keep the count at 32.
- R6: In bypass mode (`mode`=2'b00), at most one frame is held. Each accepted frame replaces the held one, including when a read falls in the same cycle.
- R7: In triggered mode (`mode`=2'b11), the buffer behaves as stream until the selected event input is seen high. From the next cycle onward it behaves as stop mode. `trigSel`=0 selects `motionEvt` and `trigSel`=1 selects `clickEvt`; the unselected input has no effect.
- R8: `wmFlag` is 1 exactly when the held count is greater than `wmLevel`. `wmIrq` follows `wmFlag` while `wmIrqEn`=1 and is 0 otherwise.
- R9: `overrunFlag` is 1 exactly when 32 frames are held. `unreadCount` then reads 31. `ovrIrq` follows `overrunFlag` while `ovrIrqEn`=1.
- R10: `unreadCount` gives the held count for 0 to 31 frames. `emptyFlag` is 1 exactly when the count is 0.
- R11: A change on `mode` flushes the buffer at the next clock edge and clears the trigger state. A frame offered in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Fill policy: 00 bypass, 01 stop, 10 stream, 11 triggered |
| trigSel | input | 1 | Trigger source: 0 motion, 1 click |
| motionEvt | input | 1 | Motion event input |
| clickEvt | input | 1 | Click event input |
| wmLevel | input | 5 | Watermark level |
| wmIrqEn | input | 1 | Watermark interrupt enable |
| ovrIrqEn | input | 1 | Overrun interrupt enable |
| sampleValid | input | 1 | New frame strobe |
| sampleFrame | input | 48 | New frame: one 16-bit sample per axis |
| readStrobe | input | 1 | Pops the head frame |
| readFrame | output | 48 | Oldest unread frame |
| unreadCount | output | 5 | Unread count, saturating at 31 |
| wmFlag | output | 1 | Count above watermark level |
| overrunFlag | output | 1 | 32 frames held |
| emptyFlag | output | 1 | No frame held |
| wmIrq | output | 1 | Watermark interrupt request |
| ovrIrq | output | 1 | Overrun interrupt request |

## Verification
The delicate collision is a read strobe landing in the same cycle as a new frame while the buffer is full. In that cycle the pop and the write, or the pop and the drop-oldest action, must combine into exactly one pointer step each.

The bench provokes this collision in stream mode and in bypass mode. It judges the result by the head frame before and after the edge, by the overrun flag staying set, and by draining the buffer and checking the complete order.

A second meeting point is the trigger event against a later write. The bench pulses the selected event, then offers a frame in the following cycle and checks that the frame is dropped.

// File: rtl/sff_pkg.sv
package sff_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_STOP   = 2'b01,
    MODE_STREAM = 2'b10,
    MODE_TRIG   = 2'b11
  } fifoMode_t;

  typedef struct packed {
    logic flush;
    logic bypassLoad;
    logic doWrite;
    logic doRead;
    logic dropOldest;
  } fifoStrobe_t;
endpackage

// File: rtl/sff_ctrl.sv
module sff_ctrl
  import sff_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             trigSel,
  input  logic             motionEvt,
  input  logic             clickEvt,
  input  logic             sampleValid,
  input  logic             readStrobe,
  input  logic [CNT_W-1:0] count,
  output fifoStrobe_t      strb
);
  logic [1:0] modeQ;
  logic       trigHit;
  logic       selEvt;
  logic       isFull;
  logic       rdOk;
  logic       stopPolicy;

  assign selEvt     = trigSel ? clickEvt : motionEvt;
  assign isFull     = (count == CNT_W'(DEPTH));
  assign rdOk       = readStrobe && (count != '0);
  assign stopPolicy = (mode == MODE_STOP) || ((mode == MODE_TRIG) && trigHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_BYPASS;
      trigHit <= 1'b0;
    end else begin
      modeQ <= mode;
      if (strb.flush) begin
        trigHit <= 1'b0;
      end else if ((mode == MODE_TRIG) && selEvt) begin
        trigHit <= 1'b1;
      end
    end
  end

  always_comb begin
    strb = '0;
    if (mode != modeQ) begin
      strb.flush = 1'b1;
    end else if (mode == MODE_BYPASS) begin
      strb.bypassLoad = sampleValid;
      strb.doRead     = rdOk && !sampleValid;
    end else if (stopPolicy) begin
      strb.doWrite = sampleValid && !isFull;
      strb.doRead  = rdOk;
    end else begin
      strb.doWrite    = sampleValid;
      strb.doRead     = rdOk;
      strb.dropOldest = sampleValid && isFull && !rdOk;
    end
  end
endmodule

// File: rtl/sff_datapath.sv
module sff_datapath
  import sff_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int AXES     = 3,
  localparam int FRAME_W = SAMPLE_W * AXES,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobe_t        strb,
  input  logic [FRAME_W-1:0] sampleFrame,
  input  logic [PTR_W-1:0]   wmLevel,
  output logic [FRAME_W-1:0] readFrame,
  output logic [CNT_W-1:0]   count,
  output logic [PTR_W-1:0]   unreadCount,
  output logic               wmFlag,
  output logic               overrunFlag,
  output logic               emptyFlag
);
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             pop;
  logic             store;

  assign pop   = strb.doRead || strb.dropOldest;
  assign store = strb.doWrite || strb.bypassLoad;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [SAMPLE_W-1:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (store) begin
        lane[wrPtr] <= sampleFrame[a*SAMPLE_W +: SAMPLE_W];
      end
    end
    assign readFrame[a*SAMPLE_W +: SAMPLE_W] = lane[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.bypassLoad) begin
      rdPtr <= wrPtr;
      wrPtr <= wrPtr + 1'b1;
      count <= CNT_W'(1);
    end else begin
      if (strb.doWrite) wrPtr <= wrPtr + 1'b1;
      if (pop)          rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(strb.doWrite) - CNT_W'(pop);
    end
  end

  assign overrunFlag = count[CNT_W-1];
  assign emptyFlag   = (count == '0);
  assign unreadCount = overrunFlag ? '1 : count[PTR_W-1:0];
  assign wmFlag      = (count > {1'b0, wmLevel});
endmodule

// File: rtl/sample_frame_fifo.sv
module sample_frame_fifo
  import sff_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 16,
  parameter int AXES     = 3,
  localparam int FRAME_W = SAMPLE_W * AXES,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               trigSel,
  input  logic               motionEvt,
  input  logic               clickEvt,
  input  logic [PTR_W-1:0]   wmLevel,
  input  logic               wmIrqEn,
  input  logic               ovrIrqEn,
  input  logic               sampleValid,
  input  logic [FRAME_W-1:0] sampleFrame,
  input  logic               readStrobe,
  output logic [FRAME_W-1:0] readFrame,
  output logic [PTR_W-1:0]   unreadCount,
  output logic               wmFlag,
  output logic               overrunFlag,
  output logic               emptyFlag,
  output logic               wmIrq,
  output logic               ovrIrq
);
  fifoStrobe_t      strb;
  logic [CNT_W-1:0] count;

  sff_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .trigSel(trigSel),
    .motionEvt(motionEvt), .clickEvt(clickEvt), .sampleValid(sampleValid),
    .readStrobe(readStrobe), .count(count), .strb(strb)
  );

  sff_datapath #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .AXES(AXES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleFrame(sampleFrame),
    .wmLevel(wmLevel), .readFrame(readFrame), .count(count),
    .unreadCount(unreadCount), .wmFlag(wmFlag), .overrunFlag(overrunFlag),
    .emptyFlag(emptyFlag)
  );

  assign wmIrq  = wmFlag && wmIrqEn;
  assign ovrIrq = overrunFlag && ovrIrqEn;
endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int FRAME_W = 48,
  parameter int PTR_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         mode,
  input logic               sampleValid,
  input logic               readStrobe,
  input logic [FRAME_W-1:0] readFrame,
  input logic [PTR_W-1:0]   unreadCount,
  input logic               wmFlag,
  input logic               overrunFlag,
  input logic               emptyFlag
);
  AST_FULL_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag |-> (unreadCount == '1) && !emptyFlag); // R9

  AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && emptyFlag && readStrobe && !sampleValid && $stable(mode)) |=> emptyFlag); // R2

  AST_STOP_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && mode == 2'b01 && $stable(mode) && overrunFlag && !readStrobe)
      |=> overrunFlag && $stable(readFrame)); // R3

  AST_STREAM_FULL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && mode == 2'b10 && $stable(mode) && overrunFlag && sampleValid) |=> overrunFlag); // R4

  AST_BYPASS_ONE_DEEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && mode == 2'b00 && $stable(mode)) |-> (unreadCount <= PTR_W'(1)) && !overrunFlag); // R6

  AST_WM_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    wmFlag |-> !emptyFlag); // R8

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && mode != $past(mode)) |=> emptyFlag); // R11
endmodule

bind sample_frame_fifo sff_checker #(.FRAME_W(FRAME_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .sampleValid(sampleValid),
  .readStrobe(readStrobe), .readFrame(readFrame), .unreadCount(unreadCount),
  .wmFlag(wmFlag), .overrunFlag(overrunFlag), .emptyFlag(emptyFlag)
);

// File: tb/sample_frame_fifo_tb_top.sv
`timescale 1ns/1ps
module sample_frame_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        trigSel = 1'b0;
  logic        motionEvt = 1'b0;
  logic        clickEvt = 1'b0;
  logic [4:0]  wmLevel = 5'd0;
  logic        wmIrqEn = 1'b0;
  logic        ovrIrqEn = 1'b0;
  logic        sampleValid = 1'b0;
  logic [47:0] sampleFrame = '0;
  logic        readStrobe = 1'b0;
  logic [47:0] readFrame;
  logic [4:0]  unreadCount;
  logic        wmFlag, overrunFlag, emptyFlag, wmIrq, ovrIrq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sample_frame_fifo dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .trigSel(trigSel),
    .motionEvt(motionEvt), .clickEvt(clickEvt), .wmLevel(wmLevel),
    .wmIrqEn(wmIrqEn), .ovrIrqEn(ovrIrqEn), .sampleValid(sampleValid),
    .sampleFrame(sampleFrame), .readStrobe(readStrobe), .readFrame(readFrame),
    .unreadCount(unreadCount), .wmFlag(wmFlag), .overrunFlag(overrunFlag),
    .emptyFlag(emptyFlag), .wmIrq(wmIrq), .ovrIrq(ovrIrq)
  );

  function automatic logic [47:0] mk(int v);
    return {16'(v), 16'(v * 3 + 7), 16'(16'hF000 ^ v)};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeF(int v);
    sampleValid = 1'b1;
    sampleFrame = mk(v);
    cyc();
    sampleValid = 1'b0;
  endtask

  task automatic readOne();
    readStrobe = 1'b1;
    cyc();
    readStrobe = 1'b0;
  endtask

  task automatic flushTo(logic [1:0] m);
    mode = (m == 2'b01) ? 2'b10 : 2'b01;
    cyc();
    mode = m;
    cyc();
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1", "empty", emptyFlag, 1);
    chk("R1", "count", unreadCount, 0);
    chk("R1", "flags", {wmFlag, overrunFlag, wmIrq, ovrIrq}, 0);
  endtask

  task automatic t_order();
    flushTo(2'b01);
    for (int i = 0; i < 3; i++) writeF(i);
    chk("R10", "count after 3", unreadCount, 3);
    chk("R10", "not empty", emptyFlag, 0);
    chk("R2", "head 0", readFrame, mk(0));
    readOne();
    chk("R2", "head 1", readFrame, mk(1));
    readOne();
    chk("R2", "head 2", readFrame, mk(2));
    readOne();
    chk("R10", "empty after drain", {emptyFlag, unreadCount}, {1'b1, 5'd0});
    readOne();
    chk("R2", "read on empty", {emptyFlag, unreadCount, overrunFlag}, {1'b1, 5'd0, 1'b0});
  endtask

  task automatic t_watermark();
    flushTo(2'b01);
    wmLevel = 5'd4;
    wmIrqEn = 1'b1;
    for (int i = 0; i < 4; i++) writeF(i);
    chk("R8", "wm at level", {wmFlag, wmIrq}, 2'b00);
    writeF(4);
    chk("R8", "wm above level", {wmFlag, wmIrq}, 2'b11);
    wmIrqEn = 1'b0;
    #1;
    chk("R8", "wm irq masked", {wmFlag, wmIrq}, 2'b10);
    wmLevel = 5'd0;
  endtask

  task automatic t_stopFull();
    flushTo(2'b01);
    ovrIrqEn = 1'b1;
    for (int i = 0; i < 32; i++) writeF(i);
    chk("R9", "full flags", {overrunFlag, ovrIrq, unreadCount}, {2'b11, 5'd31});
    writeF(99);
    chk("R3", "full write dropped head", readFrame, mk(0));
    chk("R3", "still full", overrunFlag, 1);
    readOne();
    chk("R9", "one below full", {overrunFlag, ovrIrq, unreadCount}, {2'b00, 5'd31});
    for (int i = 0; i < 31; i++) begin
      chk("R3", $sformatf("stop drain %0d", i), readFrame, mk(1 + i));
      readOne();
    end
    chk("R3", "stop drained", emptyFlag, 1);
    ovrIrqEn = 1'b0;
  endtask

  task automatic t_stream();
    flushTo(2'b10);
    for (int i = 0; i < 34; i++) writeF(i);
    chk("R4", "stream stays full", {overrunFlag, unreadCount}, {1'b1, 5'd31});
    chk("R4", "oldest dropped", readFrame, mk(2));
    readStrobe = 1'b1;
    sampleValid = 1'b1;
    sampleFrame = mk(40);
    cyc();
    readStrobe = 1'b0;
    sampleValid = 1'b0;
    chk("R5", "rd+wr full count", overrunFlag, 1);
    chk("R5", "rd+wr full head", readFrame, mk(3));
    for (int i = 0; i < 32; i++) begin
      chk("R5", $sformatf("stream drain %0d", i), readFrame, (i < 31) ? mk(3 + i) : mk(40));
      readOne();
    end
    chk("R5", "stream drained", emptyFlag, 1);
  endtask

  task automatic t_bypass();
    flushTo(2'b00);
    writeF(7);
    writeF(8);
    writeF(9);
    chk("R6", "bypass count", {unreadCount, overrunFlag}, {5'd1, 1'b0});
    chk("R6", "bypass latest", readFrame, mk(9));
    readOne();
    chk("R6", "bypass read empties", emptyFlag, 1);
    writeF(11);
    readStrobe = 1'b1;
    sampleValid = 1'b1;
    sampleFrame = mk(12);
    cyc();
    readStrobe = 1'b0;
    sampleValid = 1'b0;
    chk("R6", "bypass rd+wr", {unreadCount, readFrame}, {5'd1, mk(12)});
  endtask

  task automatic t_trigger();
    flushTo(2'b11);
    trigSel = 1'b1;
    for (int i = 0; i < 34; i++) writeF(i);
    chk("R7", "pre-trigger stream", readFrame, mk(2));
    motionEvt = 1'b1;
    cyc();
    motionEvt = 1'b0;
    writeF(50);
    chk("R7", "unselected event ignored", readFrame, mk(3));
    clickEvt = 1'b1;
    cyc();
    clickEvt = 1'b0;
    writeF(51);
    chk("R7", "post-trigger drop", {overrunFlag, readFrame}, {1'b1, mk(3)});
    readOne();
    chk("R7", "post-trigger read", {unreadCount, readFrame}, {5'd31, mk(4)});
    writeF(52);
    writeF(53);
    for (int i = 0; i < 32; i++) begin
      chk("R7", $sformatf("trig drain %0d", i), readFrame,
          (i < 30) ? mk(4 + i) : ((i == 30) ? mk(50) : mk(52)));
      readOne();
    end
    writeF(60);
    writeF(61);
    mode = 2'b10;
    sampleValid = 1'b1;
    sampleFrame = mk(62);
    cyc();
    sampleValid = 1'b0;
    chk("R11", "mode change flush", {emptyFlag, unreadCount}, {1'b1, 5'd0});
    flushTo(2'b11);
    for (int i = 0; i < 33; i++) writeF(i);
    chk("R11", "trigger cleared by flush", readFrame, mk(1));
    trigSel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    cyc();
    t_order();
    t_watermark();
    t_stopFull();
    t_stream();
    t_bypass();
    t_trigger();
    finishRun();
  end
endmodule